// File: doc/BRIEF.md
# Serial Packet Frame Transmitter

This block turns the contents of an external 64-byte transmit buffer into one serial frame. The frame goes out one bit per symbol tick, in a fixed field order: an alternating preamble, a programmable sync word, an alternating trailer, the payload bytes taken from the buffer, and, when enabled, a 16-bit CRC. The symbol tick (`sym_en`) is a one-cycle enable pulse supplied by a rate generator elsewhere. The core clock may run at any multiple of the symbol rate, including one.

The host loads the buffer and sets `fifo_level` to the number of valid bytes. It programs the field lengths and payload coding, then pulses `start`. The block addresses the buffer through `fifo_raddr` and reads `fifo_rdata` combinationally. The read pointer is cleared once the sync word has gone out, so the payload always starts at address 0.

The payload ends when the read count reaches `fifo_level`. Because that comparison is made live at each byte boundary, a host can top up the buffer while a long packet is running. Payload bits are sent raw or Manchester-coded. The CRC is always sent uncoded.

The controller moves through seven named states, each on symbol ticks except the first:

- IDLE goes to PRE on `start`.
- PRE goes to SYNC after the last preamble bit.
- SYNC goes to TRL after the last sync bit, and clears the pointer on that tick.
- TRL goes to PAY if a byte is available. With no byte available it goes to CRC when CRC is enabled, otherwise to FIN.
- PAY goes to CRC or FIN after the last symbol of the last available byte.
- CRC goes to FIN after 16 bits.
- FIN goes back to IDLE on the next tick, which drops the active flag and pulses `done`.

Top module: `frame_tx`

## Requirements
- R1: After `start`, the first field is a preamble of (`cfg_pre_bytes`+1)*8 bits alternating 1,0,1,0…, beginning with 1.
- R2: The sync word follows the preamble. `cfg_sync_sel` 0 selects 32 bits, 1 selects 48 bits, and 2 or 3 selects 64 bits, taken from the low bits of `cfg_sync_word` and sent most significant bit first.
- R3: The trailer follows the sync word. Its length is `cfg_trl_len`+4 bits for codes 0..12, and 16 bits for codes 13..15. Its bits alternate, and the first is the inverse of the last sync bit sent.
- R4: With `cfg_manch`=0, the payload is the buffer bytes at addresses 0 up to `fifo_level`-1, each sent most significant bit first. `fifo_level`=0 gives an empty payload.
- R5: With `cfg_manch`=1, each payload bit takes two ticks: a 1 is sent as 1 then 0, and a 0 as 0 then 1.
- R6: With `cfg_crc_en`=1, 16 CRC bits follow the payload, sent most significant bit first and never Manchester-coded. The CRC uses polynomial 0x1021 with seed 0xFFFF over the payload bytes, each byte taken most significant bit first. With `cfg_crc_en`=0, no CRC bits are sent.
- R7: `fifo_raddr` keeps its previous value through the preamble and sync word, reads 0 during the trailer, and otherwise changes only by incrementing.
- R8: `fifo_empty` is high exactly when the number of bytes read since the pointer was cleared equals `fifo_level`.
- R9: `tx_bit` and `pkt_active` change only on edges where `sym_en` was high, and each bit is held for one tick. `pkt_active` rises with the first preamble bit and falls one tick after the last frame bit. On that same edge, `done` pulses high for exactly one cycle.
- R10: A `start` pulse while a packet is in progress, including on the edge that produces `done`, has no effect on the frame and does not start another packet.
- R11: After reset, `tx_bit`, `pkt_active` and `done` are 0 and `fifo_raddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a packet (accepted only in IDLE) |
| sym_en | input | 1 | Symbol tick, one pulse per output bit |
| cfg_pre_bytes | input | 3 | Preamble length in bytes minus one |
| cfg_sync_sel | input | 2 | Sync length select: 0 for 32 bits, 1 for 48 bits, 2 or 3 for 64 bits |
| cfg_sync_word | input | 64 | Sync word, right-aligned |
| cfg_trl_len | input | 4 | Trailer length code |
| cfg_manch | input | 1 | Manchester-code the payload |
| cfg_crc_en | input | 1 | Append the CRC |
| fifo_level | input | 7 | Valid bytes in the buffer (0..64) |
| fifo_rdata | input | 8 | Buffer data at `fifo_raddr` |
| fifo_raddr | output | 6 | Buffer read address |
| fifo_empty | output | 1 | All valid bytes have been read |
| tx_bit | output | 1 | Serial frame bit |
| pkt_active | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The coincidence that matters is a `start` strobe on the very edge where the FIN tick produces `done` and the controller returns to IDLE. The FIN state must ignore that strobe, and only a later strobe may begin a packet. The bench provokes this by holding `start` high through a whole packet with a tick on every cycle, then releasing it in the cycle where `done` is seen. It judges the result by requiring a bit-exact frame, exactly one `done` pulse, and `pkt_active` staying low afterwards. A second case raises `start` in the middle of a packet and is judged the same way. The trailer-end byte load is checked as well: it reads address 0 on the tick after the sync-end pointer clear, and the bench confirms this through the payload contents and `fifo_raddr`.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_TRL,
        ST_PAY,
        ST_CRC,
        ST_FIN
    } ftx_state_t;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // Advance the CRC register over one byte, most significant bit first.
    function automatic logic [15:0] crc_next_byte(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        logic fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    // Sync length in bits from the select code.
    function automatic logic [6:0] sync_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 7'd32;
            2'd1:    return 7'd48;
            default: return 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/frame_tx_feed.sv
module frame_tx_feed #(
    parameter int FIFO_DEPTH = 64,
    localparam int AW = $clog2(FIFO_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_ptr,
    input  logic          load_byte,
    input  logic          pay_step,
    input  logic          crc_init,
    input  logic          crc_step,
    input  logic          manch,
    input  logic [AW:0]   fifo_level,
    input  logic [7:0]    fifo_rdata,
    output logic [AW-1:0] fifo_raddr,
    output logic          more_data,
    output logic          pay_bit,
    output logic          pay_last_sym,
    output logic          crc_bit
);
    import frame_tx_pkg::*;

    logic [AW:0]  rd_cnt;
    logic [7:0]   shreg;
    logic [2:0]   bit_idx;
    logic         half;
    logic [15:0]  crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt <= '0;
        end else if (clr_ptr) begin
            rd_cnt <= '0;
        end else if (load_byte) begin
            rd_cnt <= rd_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            half    <= 1'b0;
        end else if (load_byte) begin
            shreg   <= fifo_rdata;
            bit_idx <= '0;
            half    <= 1'b0;
        end else if (pay_step) begin
            if (manch && !half) begin
                half <= 1'b1;
            end else begin
                half    <= 1'b0;
                shreg   <= {shreg[6:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (crc_init) begin
            crc_q <= CRC_SEED;
        end else if (load_byte) begin
            crc_q <= crc_next_byte(crc_q, fifo_rdata);
        end else if (crc_step) begin
            crc_q <= {crc_q[14:0], 1'b0};
        end
    end

    assign fifo_raddr   = rd_cnt[AW-1:0];
    assign more_data    = (rd_cnt != fifo_level);
    assign pay_bit      = (manch && half) ? ~shreg[7] : shreg[7];
    assign pay_last_sym = (bit_idx == 3'd7) && (!manch || half);
    assign crc_bit      = crc_q[15];

endmodule

// File: rtl/frame_tx_seq.sv
module frame_tx_seq #(
    parameter int PRE_W  = 3,
    parameter int SYNC_W = 64,
    parameter int TRL_W  = 4,
    localparam int CNT_W = $clog2(SYNC_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sym_en,
    input  logic [PRE_W-1:0]  cfg_pre_bytes,
    input  logic [1:0]        cfg_sync_sel,
    input  logic [SYNC_W-1:0] cfg_sync_word,
    input  logic [TRL_W-1:0]  cfg_trl_len,
    input  logic              cfg_crc_en,
    input  logic              more_data,
    input  logic              pay_bit,
    input  logic              pay_last_sym,
    input  logic              crc_bit,
    output logic              clr_ptr,
    output logic              load_byte,
    output logic              pay_step,
    output logic              crc_init,
    output logic              crc_step,
    output logic              tx_bit,
    output logic              pkt_active,
    output logic              done
);
    import frame_tx_pkg::*;

    localparam logic [CNT_W-1:0] TRL_MAX_CODE = CNT_W'(12);
    localparam logic [CNT_W-1:0] TRL_BASE     = CNT_W'(4);
    localparam logic [CNT_W-1:0] TRL_CAP      = CNT_W'(16);
    localparam logic [CNT_W-1:0] CRC_LEN      = CNT_W'(16);

    ftx_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] fld_len;
    logic [CNT_W-1:0] sync_len;
    logic [CNT_W-1:0] trl_code;
    logic [CNT_W-1:0] sync_idx;
    logic             fld_last;
    logic             cur_bit;
    logic             after_data;

    assign sync_len = CNT_W'(sync_bits(cfg_sync_sel));
    assign trl_code = CNT_W'(cfg_trl_len);
    assign sync_idx = sync_len - 1'b1 - cnt;

    always_comb begin
        unique case (state)
            ST_PRE:  fld_len = (CNT_W'(cfg_pre_bytes) + 1'b1) << 3;
            ST_SYNC: fld_len = sync_len;
            ST_TRL:  fld_len = (trl_code > TRL_MAX_CODE) ? TRL_CAP : trl_code + TRL_BASE;
            ST_CRC:  fld_len = CRC_LEN;
            default: fld_len = '1;
        endcase
    end

    assign fld_last   = (cnt == fld_len - 1'b1);
    assign after_data = cfg_crc_en;

    always_comb begin
        unique case (state)
            ST_PRE:  cur_bit = ~cnt[0];
            ST_SYNC: cur_bit = cfg_sync_word[sync_idx[CNT_W-2:0]];
            ST_TRL:  cur_bit = cfg_sync_word[0] ^ ~cnt[0];
            ST_PAY:  cur_bit = pay_bit;
            ST_CRC:  cur_bit = crc_bit;
            default: cur_bit = 1'b0;
        endcase
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_PRE;
            ST_PRE:  if (sym_en && fld_last) state_nxt = ST_SYNC;
            ST_SYNC: if (sym_en && fld_last) state_nxt = ST_TRL;
            ST_TRL:  if (sym_en && fld_last)
                         state_nxt = more_data ? ST_PAY : (after_data ? ST_CRC : ST_FIN);
            ST_PAY:  if (sym_en && pay_last_sym && !more_data)
                         state_nxt = after_data ? ST_CRC : ST_FIN;
            ST_CRC:  if (sym_en && fld_last) state_nxt = ST_FIN;
            ST_FIN:  if (sym_en) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign crc_init  = (state == ST_IDLE) && start;
    assign clr_ptr   = (state == ST_SYNC) && sym_en && fld_last;
    assign load_byte = sym_en && more_data &&
                       (((state == ST_TRL) && fld_last) || ((state == ST_PAY) && pay_last_sym));
    assign pay_step  = sym_en && (state == ST_PAY);
    assign crc_step  = sym_en && (state == ST_CRC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_IDLE) begin
            cnt <= '0;
        end else if (sym_en) begin
            cnt <= (state_nxt != state) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit     <= 1'b0;
            pkt_active <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (sym_en) begin
                if (state == ST_FIN) begin
                    tx_bit     <= 1'b0;
                    pkt_active <= 1'b0;
                    done       <= 1'b1;
                end else if (state != ST_IDLE) begin
                    tx_bit     <= cur_bit;
                    pkt_active <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
    parameter int FIFO_DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           sym_en,
    input  logic [2:0]                     cfg_pre_bytes,
    input  logic [1:0]                     cfg_sync_sel,
    input  logic [63:0]                    cfg_sync_word,
    input  logic [3:0]                     cfg_trl_len,
    input  logic                           cfg_manch,
    input  logic                           cfg_crc_en,
    input  logic [$clog2(FIFO_DEPTH):0]    fifo_level,
    input  logic [7:0]                     fifo_rdata,
    output logic [$clog2(FIFO_DEPTH)-1:0]  fifo_raddr,
    output logic                           fifo_empty,
    output logic                           tx_bit,
    output logic                           pkt_active,
    output logic                           done
);
    logic clr_ptr, load_byte, pay_step, crc_init, crc_step;
    logic more_data, pay_bit, pay_last_sym, crc_bit;

    frame_tx_seq #(.PRE_W(3), .SYNC_W(64), .TRL_W(4)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sym_en       (sym_en),
        .cfg_pre_bytes(cfg_pre_bytes),
        .cfg_sync_sel (cfg_sync_sel),
        .cfg_sync_word(cfg_sync_word),
        .cfg_trl_len  (cfg_trl_len),
        .cfg_crc_en   (cfg_crc_en),
        .more_data    (more_data),
        .pay_bit      (pay_bit),
        .pay_last_sym (pay_last_sym),
        .crc_bit      (crc_bit),
        .clr_ptr      (clr_ptr),
        .load_byte    (load_byte),
        .pay_step     (pay_step),
        .crc_init     (crc_init),
        .crc_step     (crc_step),
        .tx_bit       (tx_bit),
        .pkt_active   (pkt_active),
        .done         (done)
    );

    frame_tx_feed #(.FIFO_DEPTH(FIFO_DEPTH)) u_feed (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_ptr     (clr_ptr),
        .load_byte   (load_byte),
        .pay_step    (pay_step),
        .crc_init    (crc_init),
        .crc_step    (crc_step),
        .manch       (cfg_manch),
        .fifo_level  (fifo_level),
        .fifo_rdata  (fifo_rdata),
        .fifo_raddr  (fifo_raddr),
        .more_data   (more_data),
        .pay_bit     (pay_bit),
        .pay_last_sym(pay_last_sym),
        .crc_bit     (crc_bit)
    );

    assign fifo_empty = ~more_data;

endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sym_en,
    input logic          tx_bit,
    input logic          pkt_active,
    input logic          done,
    input logic [AW-1:0] fifo_raddr
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!pkt_active && $past(pkt_active)));

    p_active_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pkt_active) |-> $past(sym_en));

    p_bit_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sym_en) |-> $stable(tx_bit));

    p_ptr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fifo_raddr) |-> (fifo_raddr == '0 || fifo_raddr == AW'($past(fifo_raddr) + 1'b1)));

endmodule

bind frame_tx frame_tx_chk #(.AW($clog2(FIFO_DEPTH))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_en    (sym_en),
    .tx_bit    (tx_bit),
    .pkt_active(pkt_active),
    .done      (done),
    .fifo_raddr(fifo_raddr)
);

// File: tb/tb_frame_tx.sv
module tb_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sym_en = 1'b0;
    logic [2:0] cfg_pre_bytes = '0;
    logic [1:0] cfg_sync_sel = '0;
    logic [63:0] cfg_sync_word = '0;
    logic [3:0] cfg_trl_len = '0;
    logic cfg_manch = 1'b0;
    logic cfg_crc_en = 1'b0;
    logic [6:0] fifo_level = '0;
    logic [7:0] fifo_rdata;
    logic [5:0] fifo_raddr;
    logic fifo_empty, tx_bit, pkt_active, done;

    logic [7:0] mem [64];
    assign fifo_rdata = mem[fifo_raddr];

    frame_tx dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sym_en(sym_en),
        .cfg_pre_bytes(cfg_pre_bytes), .cfg_sync_sel(cfg_sync_sel),
        .cfg_sync_word(cfg_sync_word), .cfg_trl_len(cfg_trl_len),
        .cfg_manch(cfg_manch), .cfg_crc_en(cfg_crc_en),
        .fifo_level(fifo_level), .fifo_rdata(fifo_rdata),
        .fifo_raddr(fifo_raddr), .fifo_empty(fifo_empty),
        .tx_bit(tx_bit), .pkt_active(pkt_active), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int div = 3;
    int divcnt = 0;

    logic exp_b [MAXB];
    logic cap_b [MAXB];
    int   nexp, ncap, ndone, trl_idx;
    int   b_pre, b_sync, b_trl, b_pay;
    logic [5:0] obs_pre_ptr, obs_trl_ptr;
    logic obs_trl_empty;
    logic sym_seen = 1'b0;
    logic done_prev = 1'b0;
    int   prev_len = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        sym_seen <= sym_en;
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            divcnt = 0;
            sym_en = 1'b0;
        end else begin
            sym_en = (divcnt == 0);
            divcnt = (divcnt + 1 >= div) ? 0 : divcnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (sym_seen && pkt_active && ncap < MAXB) begin
                if (ncap == 0) obs_pre_ptr = fifo_raddr;
                if (ncap == trl_idx) begin
                    obs_trl_ptr   = fifo_raddr;
                    obs_trl_empty = fifo_empty;
                end
                cap_b[ncap] = tx_bit;
                ncap++;
            end
            if (done) ndone++;
            if (done && done_prev)
                check(1'b0, "R9", "done longer than one cycle", 2, 1);
            done_prev = done;
        end
    end

    function automatic logic [15:0] ref_crc(input int len);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < len; k++) begin
            for (int b = 7; b >= 0; b--) begin
                if (c[15] != mem[k][b]) c = (c << 1) ^ 16'h1021;
                else                    c = c << 1;
            end
        end
        return c;
    endfunction

    task automatic build_expected(input int len);
        int nsync, ntrl;
        logic [15:0] c;
        nexp = 0;
        for (int i = 0; i < (int'(cfg_pre_bytes) + 1) * 8; i++) begin exp_b[nexp] = (i % 2 == 0); nexp++; end
        b_pre = nexp;
        nsync = (cfg_sync_sel == 0) ? 32 : (cfg_sync_sel == 1) ? 48 : 64;
        for (int i = nsync - 1; i >= 0; i--) begin exp_b[nexp] = cfg_sync_word[i]; nexp++; end
        b_sync = nexp;
        ntrl = (cfg_trl_len > 12) ? 16 : int'(cfg_trl_len) + 4;
        for (int i = 0; i < ntrl; i++) begin
            exp_b[nexp] = (i % 2 == 0) ? ~cfg_sync_word[0] : cfg_sync_word[0];
            nexp++;
        end
        b_trl = nexp;
        for (int k = 0; k < len; k++) begin
            for (int b = 7; b >= 0; b--) begin
                exp_b[nexp] = mem[k][b]; nexp++;
                if (cfg_manch) begin exp_b[nexp] = ~mem[k][b]; nexp++; end
            end
        end
        b_pay = nexp;
        if (cfg_crc_en) begin
            c = ref_crc(len);
            for (int i = 15; i >= 0; i--) begin exp_b[nexp] = c[i]; nexp++; end
        end
    endtask

    task automatic cmp_region(input int lo, input int hi, input string req, input string what);
        int bad = -1;
        for (int i = lo; i < hi; i++)
            if (bad < 0 && (i >= ncap || cap_b[i] !== exp_b[i])) bad = i;
        if (bad < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, what, (bad < ncap) ? int'(cap_b[bad]) : -1, int'(exp_b[bad]));
    endtask

    task automatic run_pkt(input int len, input bit mid_start, input bit hold_start);
        int t;
        fifo_level = 7'(len);
        build_expected(len);
        trl_idx = b_sync;
        ncap = 0;
        ndone = 0;
        obs_trl_ptr = 6'h3F;
        obs_trl_empty = 1'bx;
        @(negedge clk) start = 1'b1;
        if (!hold_start) @(negedge clk) start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (mid_start && t == 60) start = 1'b1;
            else if (mid_start && t == 61) start = 1'b0;
        end
        start = 1'b0;   // released in the cycle done is seen
        repeat (3 * div + 4) @(negedge clk);
        check(ndone == 1, "R9", "done pulses per packet", ndone, 1);
        check(!pkt_active, hold_start || mid_start ? "R10" : "R9", "active after done", int'(pkt_active), 0);
        check(ncap == nexp, "R9", "frame length in ticks", ncap, nexp);
        cmp_region(0, b_pre, "R1", "preamble bits");
        cmp_region(b_pre, b_sync, "R2", "sync bits");
        cmp_region(b_sync, b_trl, "R3", "trailer bits");
        cmp_region(b_trl, b_pay, cfg_manch ? "R5" : "R4", "payload bits");
        if (cfg_crc_en) cmp_region(b_pay, nexp, "R6", "crc bits");
        else check(ncap == b_pay, "R6", "no crc when disabled", ncap, b_pay);
        if (mid_start || hold_start) cmp_region(0, nexp, "R10", "frame unaffected by extra start");
        check(obs_pre_ptr == 6'(prev_len), "R7", "pointer held in preamble", int'(obs_pre_ptr), prev_len % 64);
        check(obs_trl_ptr == 6'd0, "R7", "pointer zero in trailer", int'(obs_trl_ptr), 0);
        check(obs_trl_empty === (len == 0), "R8", "empty flag in trailer", int'(obs_trl_empty), int'(len == 0));
        check(fifo_empty == 1'b1, "R8", "empty after packet", int'(fifo_empty), 1);
        prev_len = len;
    endtask

    task automatic set_cfg(input int pre, input int ss, input int trl, input bit m, input bit c);
        cfg_pre_bytes = 3'(pre);
        cfg_sync_sel  = 2'(ss);
        cfg_trl_len   = 4'(trl);
        cfg_manch     = m;
        cfg_crc_en    = c;
        cfg_sync_word = {$urandom, $urandom};
        for (int k = 0; k < 64; k++) mem[k] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        check(tx_bit == 0 && pkt_active == 0 && done == 0, "R11", "reset outputs",
              int'({tx_bit, pkt_active, done}), 0);
        check(fifo_raddr == 0, "R11", "reset address", int'(fifo_raddr), 0);
        check(fifo_empty == 1, "R8", "empty at reset with level 0", int'(fifo_empty), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Directed corners
        set_cfg(0, 0, 0, 0, 0);  run_pkt(0, 0, 0);    // shortest frame, empty payload
        set_cfg(0, 1, 0, 0, 1);  run_pkt(0, 0, 0);    // empty payload, seed-only crc
        set_cfg(7, 2, 12, 1, 1); div = 1; run_pkt(64, 0, 0); // longest, tick every cycle
        set_cfg(3, 3, 15, 0, 1); div = 3; run_pkt(5, 0, 0);  // clamped trailer, select 3
        set_cfg(2, 0, 13, 1, 0); run_pkt(3, 1, 0);    // start mid-packet
        set_cfg(1, 1, 5, 0, 1);  div = 1; run_pkt(4, 0, 1); // start held onto done edge

        // Constrained random
        for (int n = 0; n < 16; n++) begin
            set_cfg(int'($urandom % 8), int'($urandom % 4), int'($urandom % 16),
                    1'($urandom), 1'($urandom));
            div = 1 + int'($urandom % 4);
            run_pkt(int'($urandom % 24), 0, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule